// File: doc/BRIEF.md
# Serial Flash Geometry Identifier

This block runs once after reset, and again on request, to find out which buffered serial flash sits on the bus and what its memory layout is. It does not drive the serial wires. It asks an external SPI byte engine for two kinds of read transaction. The first reads the manufacturer/device identifier. The second reads the status byte. It then turns the bytes it gets back into a geometry: page size in bytes, the shift that places a page number inside a device address, the number of pages, the total byte count, and a flag that marks a power-of-two page size.

Detection has two paths. If the first identifier byte carries the expected vendor code, the 24-bit identifier is looked up in a built-in table. Some identifiers name parts that can run with either page size; for those, a status read follows and status bit 0 picks the variant. If the vendor byte does not match, the block assumes an older part and decodes a density code held in status bits [5:2]. A missing device and a device that cannot be classified are each reported on their own flag. The geometry outputs carry meaning only while `done_o` is high and neither error flag is set.

The engine interface is a request/accept handshake followed by a byte stream and an end-of-transaction strobe. A request consists of `cmd_valid_o`, an opcode and a read length. The engine accepts it with `cmd_ready_i`. Each received byte arrives with `rx_valid_i`, and `cmd_done_i` marks the end of the transaction.

Top module: `flash_geom_ident`

## Requirements
- R1: While reset is held, `done_o`, `cmd_valid_o`, both error flags and all geometry outputs are 0. After reset is released, the first request issued is the identifier read: opcode 0x9F with a read length of 5 bytes.
- R2: Once `cmd_valid_o` is raised, it stays high with an unchanged opcode and length until a cycle in which `cmd_ready_i` is high.
- R3: The identifier is formed from the first three received bytes, the first byte being bits [23:16]. When bits [23:16] are not 0x1F, the block issues a status read (opcode 0xD7, length 1) and takes the legacy path.
- R4: The identifiers 0x1F2200, 0x1F2300, 0x1F2400, 0x1F2500, 0x1F2600, 0x1F2701 and 0x1F2800 name dual-size parts. Their page counts are 512, 1024, 2048, 4096, 4096, 8192 and 8192, and their power-of-two page sizes are 256, 256, 256, 256, 512, 512 and 1024. For these identifiers one status read is issued. Status bit 0 set yields the power-of-two size, shift log2(size) and `pow2_o`=1. Status bit 0 clear yields the extended size, which is the power-of-two size plus 1/32 of it, with shift one higher and `pow2_o`=0.
- R5: Identifier 0x1F2700 yields 8192 pages of 528 bytes with shift 10 and `pow2_o`=0, and no status read is issued.
- R6: A vendor byte of 0x1F with an identifier not listed in R4 or R5 sets `err_unsup_o`, and no status read is issued.
- R7: On the legacy path, a status of 0x00 or 0xFF sets `err_nodev_o`.
- R8: On the legacy path, status bits [5:2] decode to a geometry with `pow2_o`=0. The codes map as follows: 3 gives 512 pages of 264 bytes, 5 gives 1024×264, 7 gives 2048×264 and 9 gives 4096×264. Code 11 gives 4096×528 and 13 gives 8192×528, both with shift 10. Codes 14 and 15 give 8192×1056 with shift 11. A 264-byte page uses shift 9.
- R9: On the legacy path, any other nonzero, non-0xFF status whose code is not listed in R8 sets `err_unsup_o`.
- R10: `total_bytes_o` equals page count times page size. The geometry outputs and `pow2_o` are 0 whenever `done_o` is low or an error flag is set. At most one error flag is high.
- R11: A one-cycle `start_i` while `done_o` is high drops `done_o` on the next cycle and begins a fresh identifier read. A `start_i` while detection is in progress has no effect.
- R12: `done_o` rises exactly two cycles after the end-of-transaction strobe of the last read of a detection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Single-cycle request to rerun detection |
| cmd_valid_o | output | 1 | Read request to the byte engine |
| cmd_opcode_o | output | 8 | Opcode of the requested read |
| cmd_len_o | output | 3 | Number of bytes to read |
| cmd_ready_i | input | 1 | Engine accepts the request |
| rx_valid_i | input | 1 | Received byte valid |
| rx_data_i | input | 8 | Received byte |
| cmd_done_i | input | 1 | End of the current read transaction |
| done_o | output | 1 | Detection finished; results valid |
| err_nodev_o | output | 1 | No device present |
| err_unsup_o | output | 1 | Device present but not classifiable |
| pow2_o | output | 1 | Page size is a power of two |
| page_size_o | output | 11 | Page size in bytes |
| page_shift_o | output | 4 | Page-number shift within a device address |
| page_count_o | output | 14 | Number of pages |
| total_bytes_o | output | 24 | Page count times page size |

## Verification
The bench targets the points where the two detection paths meet. A vendor match with status 0x00 must still produce a geometry, because the no-device rule belongs only to the legacy path; a design that applied the rule globally would report a missing device for a valid part. The single-size identifier 0x1F2700 sits next to the dual-size 0x1F2701; a table that merged them would issue a status read that should not happen, or choose a 512-byte page. A vendor byte one off from 0x1F must fall to the legacy decoder, and the paired codes 14/15 must both decode to the largest part. A start pulse issued mid-transaction must not launch a second identifier read, and `done_o` must appear exactly two cycles after the final strobe.

// File: rtl/flash_geom_pkg.sv
package flash_geom_pkg;

    localparam int unsigned ID_W    = 24;
    localparam int unsigned ID_KEEP = 3;
    localparam int unsigned KEEP_W  = $clog2(ID_KEEP + 1);

    typedef enum logic [2:0] {
        S_BOOT    = 3'd0,
        S_ID_REQ  = 3'd1,
        S_ID_RX   = 3'd2,
        S_ID_EVAL = 3'd3,
        S_ST_REQ  = 3'd4,
        S_ST_RX   = 3'd5,
        S_ST_EVAL = 3'd6,
        S_DONE    = 3'd7
    } seq_state_e;

    // compact geometry code: page count and base page size as powers of two
    typedef struct packed {
        logic       hit;
        logic       dual;
        logic [3:0] pages_log2;
        logic [3:0] base_log2;
    } geom_code_t;

    typedef struct packed {
        seq_state_e        st;
        logic [KEEP_W-1:0] kept;
        logic [ID_W-1:0]   id;
        logic [7:0]        status;
        logic              jedec_path;
        geom_code_t        code;
        logic              pow2;
        logic              err_nodev;
        logic              err_unsup;
    } seq_regs_t;

endpackage

// File: rtl/flash_id_lookup.sv
module flash_id_lookup
    import flash_geom_pkg::*;
(
    input  logic [ID_W-1:0] id_i,
    output geom_code_t      code_o
);

    typedef struct packed {
        logic [ID_W-1:0] id;
        logic            dual;
        logic [3:0]      pages_log2;
        logic [3:0]      base_log2;
    } id_entry_t;

    localparam int unsigned N_ENTRIES = 8;

    localparam id_entry_t TABLE [N_ENTRIES] = '{
        '{24'h1F2200, 1'b1, 4'd9,  4'd8},
        '{24'h1F2300, 1'b1, 4'd10, 4'd8},
        '{24'h1F2400, 1'b1, 4'd11, 4'd8},
        '{24'h1F2500, 1'b1, 4'd12, 4'd8},
        '{24'h1F2600, 1'b1, 4'd12, 4'd9},
        '{24'h1F2700, 1'b0, 4'd13, 4'd9},
        '{24'h1F2701, 1'b1, 4'd13, 4'd9},
        '{24'h1F2800, 1'b1, 4'd13, 4'd10}
    };

    always_comb begin
        code_o = '0;
        for (int i = 0; i < int'(N_ENTRIES); i++) begin
            if (!code_o.hit && id_i == TABLE[i].id) begin
                code_o.hit        = 1'b1;
                code_o.dual       = TABLE[i].dual;
                code_o.pages_log2 = TABLE[i].pages_log2;
                code_o.base_log2  = TABLE[i].base_log2;
            end
        end
    end

endmodule

// File: rtl/flash_legacy_decode.sv
module flash_legacy_decode
    import flash_geom_pkg::*;
(
    input  logic [7:0] status_i,
    output logic       absent_o,
    output geom_code_t code_o
);

    logic [3:0] density;

    assign density  = status_i[5:2];
    assign absent_o = (status_i == 8'h00) || (status_i == 8'hFF);

    always_comb begin
        code_o      = '0;
        code_o.hit  = 1'b1;
        code_o.dual = 1'b0;
        unique case (density)
            4'd3:  begin code_o.pages_log2 = 4'd9;  code_o.base_log2 = 4'd8;  end
            4'd5:  begin code_o.pages_log2 = 4'd10; code_o.base_log2 = 4'd8;  end
            4'd7:  begin code_o.pages_log2 = 4'd11; code_o.base_log2 = 4'd8;  end
            4'd9:  begin code_o.pages_log2 = 4'd12; code_o.base_log2 = 4'd8;  end
            4'd11: begin code_o.pages_log2 = 4'd12; code_o.base_log2 = 4'd9;  end
            4'd13: begin code_o.pages_log2 = 4'd13; code_o.base_log2 = 4'd9;  end
            4'd14,
            4'd15: begin code_o.pages_log2 = 4'd13; code_o.base_log2 = 4'd10; end
            default: code_o = '0;
        endcase
    end

endmodule

// File: rtl/flash_geom_calc.sv
module flash_geom_calc
    import flash_geom_pkg::*;
#(
    parameter int unsigned SIZE_W  = 11,
    parameter int unsigned SHIFT_W = 4,
    parameter int unsigned PAGES_W = 14,
    parameter int unsigned TOTAL_W = 24,
    parameter int unsigned SPARE_DIV_LOG2 = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid_i,
    input  logic               pow2_i,
    input  geom_code_t         code_i,
    output logic               pow2_o,
    output logic [SIZE_W-1:0]  page_size_o,
    output logic [SHIFT_W-1:0] page_shift_o,
    output logic [PAGES_W-1:0] page_count_o,
    output logic [TOTAL_W-1:0] total_bytes_o
);

    logic [SIZE_W-1:0] base_size;
    logic [SIZE_W-1:0] spare_size;
    logic [SIZE_W-1:0] size_raw;

    assign base_size  = SIZE_W'(1) << code_i.base_log2;
    assign spare_size = base_size >> SPARE_DIV_LOG2;
    assign size_raw   = pow2_i ? base_size : (base_size + spare_size);

    always_comb begin
        if (valid_i) begin
            pow2_o        = pow2_i;
            page_size_o   = size_raw;
            page_shift_o  = pow2_i ? SHIFT_W'(code_i.base_log2)
                                   : SHIFT_W'(code_i.base_log2) + SHIFT_W'(1);
            page_count_o  = PAGES_W'(1) << code_i.pages_log2;
            total_bytes_o = TOTAL_W'(size_raw) << code_i.pages_log2;
        end else begin
            pow2_o        = 1'b0;
            page_size_o   = '0;
            page_shift_o  = '0;
            page_count_o  = '0;
            total_bytes_o = '0;
        end
    end

    // R4
    pow2_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && pow2_i) |-> ($countones(page_size_o) == 1));

endmodule

// File: rtl/flash_id_seq.sv
module flash_id_seq
    import flash_geom_pkg::*;
#(
    parameter logic [7:0]  VENDOR_CODE = 8'h1F,
    parameter logic [7:0]  OP_ID       = 8'h9F,
    parameter logic [7:0]  OP_STATUS   = 8'hD7,
    parameter int unsigned ID_RD_BYTES = 5,
    parameter int unsigned LEN_W       = $clog2(ID_RD_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              cmd_valid_o,
    output logic [7:0]        cmd_opcode_o,
    output logic [LEN_W-1:0]  cmd_len_o,
    input  logic              cmd_ready_i,
    input  logic              rx_valid_i,
    input  logic [7:0]        rx_data_i,
    input  logic              cmd_done_i,
    input  geom_code_t        lookup_i,
    input  logic              legacy_absent_i,
    input  geom_code_t        legacy_i,
    output logic [ID_W-1:0]   id_o,
    output logic [7:0]        status_o,
    output logic              done_o,
    output logic              err_nodev_o,
    output logic              err_unsup_o,
    output logic              pow2_o,
    output geom_code_t        code_o
);

    seq_regs_t q, d;

    always_comb begin
        d = q;
        unique case (q.st)
            S_BOOT: d.st = S_ID_REQ;
            S_ID_REQ: begin
                if (cmd_ready_i) begin
                    d.st   = S_ID_RX;
                    d.kept = '0;
                    d.id   = '0;
                end
            end
            S_ID_RX: begin
                if (rx_valid_i && q.kept != KEEP_W'(ID_KEEP)) begin
                    d.id   = {q.id[ID_W-9:0], rx_data_i};
                    d.kept = q.kept + KEEP_W'(1);
                end
                if (cmd_done_i) d.st = S_ID_EVAL;
            end
            S_ID_EVAL: begin
                if (q.id[ID_W-1:ID_W-8] != VENDOR_CODE) begin
                    d.jedec_path = 1'b0;
                    d.st         = S_ST_REQ;
                end else if (!lookup_i.hit) begin
                    d.err_unsup = 1'b1;
                    d.st        = S_DONE;
                end else if (lookup_i.dual) begin
                    d.jedec_path = 1'b1;
                    d.st         = S_ST_REQ;
                end else begin
                    d.code = lookup_i;
                    d.pow2 = 1'b0;
                    d.st   = S_DONE;
                end
            end
            S_ST_REQ: begin
                if (cmd_ready_i) begin
                    d.st   = S_ST_RX;
                    d.kept = '0;
                end
            end
            S_ST_RX: begin
                if (rx_valid_i && q.kept == '0) begin
                    d.status = rx_data_i;
                    d.kept   = KEEP_W'(1);
                end
                if (cmd_done_i) d.st = S_ST_EVAL;
            end
            S_ST_EVAL: begin
                d.st = S_DONE;
                if (q.jedec_path) begin
                    d.code = lookup_i;
                    d.pow2 = q.status[0];
                end else if (legacy_absent_i) begin
                    d.err_nodev = 1'b1;
                end else if (!legacy_i.hit) begin
                    d.err_unsup = 1'b1;
                end else begin
                    d.code = legacy_i;
                    d.pow2 = 1'b0;
                end
            end
            S_DONE: begin
                if (start_i) begin
                    d.st         = S_ID_REQ;
                    d.err_nodev  = 1'b0;
                    d.err_unsup  = 1'b0;
                    d.code       = '0;
                    d.pow2       = 1'b0;
                    d.jedec_path = 1'b0;
                end
            end
            default: d.st = S_BOOT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cmd_valid_o  = (q.st == S_ID_REQ) || (q.st == S_ST_REQ);
    assign cmd_opcode_o = (q.st == S_ST_REQ) ? OP_STATUS : OP_ID;
    assign cmd_len_o    = (q.st == S_ST_REQ) ? LEN_W'(1) : LEN_W'(ID_RD_BYTES);
    assign id_o         = q.id;
    assign status_o     = q.status;
    assign done_o       = (q.st == S_DONE);
    assign err_nodev_o  = q.err_nodev;
    assign err_unsup_o  = q.err_unsup;
    assign pow2_o       = q.pow2;
    assign code_o       = q.code;

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && !cmd_ready_i) |=>
            (cmd_valid_o && $stable(cmd_opcode_o) && $stable(cmd_len_o)));

    // R10
    one_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_nodev_o, err_unsup_o}));

    // R11
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && start_i) |=> (!done_o && cmd_valid_o && cmd_opcode_o == OP_ID));

    // R12
    done_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(cmd_done_i, 2));

endmodule

// File: rtl/flash_geom_ident.sv
module flash_geom_ident
    import flash_geom_pkg::*;
#(
    parameter logic [7:0]  VENDOR_CODE = 8'h1F,
    parameter logic [7:0]  OP_ID       = 8'h9F,
    parameter logic [7:0]  OP_STATUS   = 8'hD7,
    parameter int unsigned ID_RD_BYTES = 5,
    parameter int unsigned SIZE_W      = 11,
    parameter int unsigned SHIFT_W     = 4,
    parameter int unsigned PAGES_W     = 14,
    parameter int unsigned TOTAL_W     = 24,
    localparam int unsigned LEN_W      = $clog2(ID_RD_BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    output logic               cmd_valid_o,
    output logic [7:0]         cmd_opcode_o,
    output logic [LEN_W-1:0]   cmd_len_o,
    input  logic               cmd_ready_i,
    input  logic               rx_valid_i,
    input  logic [7:0]         rx_data_i,
    input  logic               cmd_done_i,
    output logic               done_o,
    output logic               err_nodev_o,
    output logic               err_unsup_o,
    output logic               pow2_o,
    output logic [SIZE_W-1:0]  page_size_o,
    output logic [SHIFT_W-1:0] page_shift_o,
    output logic [PAGES_W-1:0] page_count_o,
    output logic [TOTAL_W-1:0] total_bytes_o
);

    logic [ID_W-1:0] id_w;
    logic [7:0]      status_w;
    geom_code_t      lookup_w;
    geom_code_t      legacy_w;
    geom_code_t      code_w;
    logic            absent_w;
    logic            pow2_sel_w;
    logic            geom_ok_w;

    flash_id_lookup u_lookup (
        .id_i   (id_w),
        .code_o (lookup_w)
    );

    flash_legacy_decode u_legacy (
        .status_i (status_w),
        .absent_o (absent_w),
        .code_o   (legacy_w)
    );

    flash_id_seq #(
        .VENDOR_CODE (VENDOR_CODE),
        .OP_ID       (OP_ID),
        .OP_STATUS   (OP_STATUS),
        .ID_RD_BYTES (ID_RD_BYTES),
        .LEN_W       (LEN_W)
    ) u_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start_i),
        .cmd_valid_o     (cmd_valid_o),
        .cmd_opcode_o    (cmd_opcode_o),
        .cmd_len_o       (cmd_len_o),
        .cmd_ready_i     (cmd_ready_i),
        .rx_valid_i      (rx_valid_i),
        .rx_data_i       (rx_data_i),
        .cmd_done_i      (cmd_done_i),
        .lookup_i        (lookup_w),
        .legacy_absent_i (absent_w),
        .legacy_i        (legacy_w),
        .id_o            (id_w),
        .status_o        (status_w),
        .done_o          (done_o),
        .err_nodev_o     (err_nodev_o),
        .err_unsup_o     (err_unsup_o),
        .pow2_o          (pow2_sel_w),
        .code_o          (code_w)
    );

    assign geom_ok_w = done_o && !err_nodev_o && !err_unsup_o && code_w.hit;

    flash_geom_calc #(
        .SIZE_W  (SIZE_W),
        .SHIFT_W (SHIFT_W),
        .PAGES_W (PAGES_W),
        .TOTAL_W (TOTAL_W)
    ) u_calc (
        .clk           (clk),
        .rst_n         (rst_n),
        .valid_i       (geom_ok_w),
        .pow2_i        (pow2_sel_w),
        .code_i        (code_w),
        .pow2_o        (pow2_o),
        .page_size_o   (page_size_o),
        .page_shift_o  (page_shift_o),
        .page_count_o  (page_count_o),
        .total_bytes_o (total_bytes_o)
    );

endmodule

// File: tb/tb_flash_geom_ident.sv
module tb_flash_geom_ident;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic        cmd_valid_o;
    logic [7:0]  cmd_opcode_o;
    logic [2:0]  cmd_len_o;
    logic        cmd_ready_i;
    logic        rx_valid_i;
    logic [7:0]  rx_data_i;
    logic        cmd_done_i;
    logic        done_o, err_nodev_o, err_unsup_o, pow2_o;
    logic [10:0] page_size_o;
    logic [3:0]  page_shift_o;
    logic [13:0] page_count_o;
    logic [23:0] total_bytes_o;

    always #2.5 clk = ~clk;

    flash_geom_ident dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .cmd_valid_o(cmd_valid_o), .cmd_opcode_o(cmd_opcode_o), .cmd_len_o(cmd_len_o),
        .cmd_ready_i(cmd_ready_i), .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i),
        .cmd_done_i(cmd_done_i), .done_o(done_o), .err_nodev_o(err_nodev_o),
        .err_unsup_o(err_unsup_o), .pow2_o(pow2_o), .page_size_o(page_size_o),
        .page_shift_o(page_shift_o), .page_count_o(page_count_o),
        .total_bytes_o(total_bytes_o)
    );

    typedef struct packed {
        logic [23:0] id;
        logic [7:0]  st;
        logic [10:0] size;
        logic [3:0]  shift;
        logic [13:0] pages;
        logic        pow2;
        logic        nodev;
        logic        unsup;
        logic [1:0]  st_reads;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        '{24'h1F2400, 8'h01, 11'd256,  4'd8,  14'd2048, 1'b1, 1'b0, 1'b0, 2'd1, 4'd4},
        '{24'h1F2400, 8'hAC, 11'd264,  4'd9,  14'd2048, 1'b0, 1'b0, 1'b0, 2'd1, 4'd4},
        '{24'h1F2600, 8'h8D, 11'd512,  4'd9,  14'd4096, 1'b1, 1'b0, 1'b0, 2'd1, 4'd4},
        '{24'h1F2600, 8'h8C, 11'd528,  4'd10, 14'd4096, 1'b0, 1'b0, 1'b0, 2'd1, 4'd4},
        '{24'h1F2800, 8'hBD, 11'd1024, 4'd10, 14'd8192, 1'b1, 1'b0, 1'b0, 2'd1, 4'd4},
        '{24'h1F2800, 8'hBC, 11'd1056, 4'd11, 14'd8192, 1'b0, 1'b0, 1'b0, 2'd1, 4'd4},
        '{24'h1F2200, 8'h01, 11'd256,  4'd8,  14'd512,  1'b1, 1'b0, 1'b0, 2'd1, 4'd4},
        '{24'h1F2500, 8'h00, 11'd264,  4'd9,  14'd4096, 1'b0, 1'b0, 1'b0, 2'd1, 4'd4},
        '{24'h1F2701, 8'hFF, 11'd512,  4'd9,  14'd8192, 1'b1, 1'b0, 1'b0, 2'd1, 4'd4},
        '{24'h1F2700, 8'h01, 11'd528,  4'd10, 14'd8192, 1'b0, 1'b0, 1'b0, 2'd0, 4'd5},
        '{24'h1F2999, 8'h00, 11'd0,    4'd0,  14'd0,    1'b0, 1'b0, 1'b1, 2'd0, 4'd6},
        '{24'h1F0000, 8'h0C, 11'd0,    4'd0,  14'd0,    1'b0, 1'b0, 1'b1, 2'd0, 4'd6},
        '{24'h7F1234, 8'h0C, 11'd264,  4'd9,  14'd512,  1'b0, 1'b0, 1'b0, 2'd1, 4'd8},
        '{24'h000000, 8'h94, 11'd264,  4'd9,  14'd1024, 1'b0, 1'b0, 1'b0, 2'd1, 4'd8},
        '{24'hFFFFFF, 8'h1C, 11'd264,  4'd9,  14'd2048, 1'b0, 1'b0, 1'b0, 2'd1, 4'd8},
        '{24'h1E2400, 8'hA4, 11'd264,  4'd9,  14'd4096, 1'b0, 1'b0, 1'b0, 2'd1, 4'd8},
        '{24'h7F1234, 8'h2C, 11'd528,  4'd10, 14'd4096, 1'b0, 1'b0, 1'b0, 2'd1, 4'd8},
        '{24'h7F1234, 8'h34, 11'd528,  4'd10, 14'd8192, 1'b0, 1'b0, 1'b0, 2'd1, 4'd8},
        '{24'h7F1234, 8'h38, 11'd1056, 4'd11, 14'd8192, 1'b0, 1'b0, 1'b0, 2'd1, 4'd8},
        '{24'h7F1234, 8'hBF, 11'd1056, 4'd11, 14'd8192, 1'b0, 1'b0, 1'b0, 2'd1, 4'd8},
        '{24'h7F1234, 8'h00, 11'd0,    4'd0,  14'd0,    1'b0, 1'b1, 1'b0, 2'd1, 4'd7},
        '{24'hFFFFFF, 8'hFF, 11'd0,    4'd0,  14'd0,    1'b0, 1'b1, 1'b0, 2'd1, 4'd7},
        '{24'h7F1234, 8'h90, 11'd0,    4'd0,  14'd0,    1'b0, 1'b0, 1'b1, 2'd1, 4'd9},
        '{24'h7F1234, 8'h84, 11'd0,    4'd0,  14'd0,    1'b0, 1'b0, 1'b1, 2'd1, 4'd9},
        '{24'h7F1234, 8'h40, 11'd0,    4'd0,  14'd0,    1'b0, 1'b0, 1'b1, 2'd1, 4'd9}
    };

    int   checks = 0;
    int   fails  = 0;
    int   cyc    = 0;
    int   done_cyc = 0;
    int   n_id = 0;
    int   n_st = 0;
    vec_t cfg;
    logic [7:0] eng_op;
    int   eng_len;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic string tag_name(input logic [3:0] r);
        case (r)
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] eng_byte(input logic [7:0] op, input int b);
        if (op == 8'hD7) return cfg.st;
        case (b)
            0: return cfg.id[23:16];
            1: return cfg.id[15:8];
            2: return cfg.id[7:0];
            3: return 8'hA5;
            default: return 8'h5A;
        endcase
    endfunction

    // behavioural byte engine: two-cycle accept delay, then bytes, then end strobe
    initial begin : engine
        cmd_ready_i = 1'b0;
        rx_valid_i  = 1'b0;
        rx_data_i   = 8'h00;
        cmd_done_i  = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && cmd_valid_o) begin
                eng_op  = cmd_opcode_o;
                eng_len = int'(cmd_len_o);
                if (eng_op == 8'h9F) begin
                    n_id++;
                    check(eng_len == 5, "R1", "identifier read length", eng_len, 5);
                end else if (eng_op == 8'hD7) begin
                    n_st++;
                    check(eng_len == 1, "R3", "status read length", eng_len, 1);
                end else begin
                    check(1'b0, "R3", "unknown opcode", int'(eng_op), 'hD7);
                end
                for (int k = 0; k < 2; k++) begin
                    @(negedge clk);
                    check(cmd_valid_o === 1'b1 && cmd_opcode_o === eng_op &&
                          int'(cmd_len_o) == eng_len, "R2", "request held",
                          int'(cmd_opcode_o), int'(eng_op));
                end
                cmd_ready_i = 1'b1;
                @(negedge clk);
                cmd_ready_i = 1'b0;
                for (int b = 0; b < eng_len; b++) begin
                    rx_valid_i = 1'b1;
                    rx_data_i  = eng_byte(eng_op, b);
                    @(negedge clk);
                end
                rx_valid_i = 1'b0;
                cmd_done_i = 1'b1;
                done_cyc   = cyc;
                @(negedge clk);
                cmd_done_i = 1'b0;
            end
        end
    end

    task automatic wait_done(input string req);
        int guard = 0;
        @(negedge clk);
        while (!done_o && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        check(done_o === 1'b1, req, "detection finished", int'(done_o), 1);
        // R12: done appears two cycles after the final end strobe
        check(cyc - done_cyc == 2, "R12", "done latency", cyc - done_cyc, 2);
    endtask

    task automatic check_result(input vec_t v, input int idx);
        string t;
        int exp_total;
        t = tag_name(v.req);
        exp_total = int'(v.pages) * int'(v.size);
        check(pow2_o == v.pow2, t, $sformatf("vec %0d pow2", idx), int'(pow2_o), int'(v.pow2));
        check(page_size_o == v.size, t, $sformatf("vec %0d page size", idx),
              int'(page_size_o), int'(v.size));
        check(page_shift_o == v.shift, t, $sformatf("vec %0d shift", idx),
              int'(page_shift_o), int'(v.shift));
        check(page_count_o == v.pages, t, $sformatf("vec %0d pages", idx),
              int'(page_count_o), int'(v.pages));
        check(int'(total_bytes_o) == exp_total, "R10", $sformatf("vec %0d total", idx),
              int'(total_bytes_o), exp_total);
        check(err_nodev_o == v.nodev, t, $sformatf("vec %0d no-device", idx),
              int'(err_nodev_o), int'(v.nodev));
        check(err_unsup_o == v.unsup, t, $sformatf("vec %0d unsupported", idx),
              int'(err_unsup_o), int'(v.unsup));
        check(n_id == 1, t, $sformatf("vec %0d id reads", idx), n_id, 1);
        check(n_st == int'(v.st_reads), t, $sformatf("vec %0d status reads", idx),
              n_st, int'(v.st_reads));
    endtask

    task automatic restart();
        n_id = 0;
        n_st = 0;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // R11 / R10: done drops next cycle, geometry cleared
        check(done_o === 1'b0, "R11", "done low after start", int'(done_o), 0);
        check(page_size_o == '0 && total_bytes_o == '0 && !pow2_o &&
              !err_nodev_o && !err_unsup_o, "R10", "outputs cleared while busy",
              int'(page_size_o), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        start_i = 1'b0;
        rst_n   = 1'b0;
        cfg     = VECS[0];
        repeat (4) @(negedge clk);
        // R1: reset state
        check(done_o === 1'b0 && cmd_valid_o === 1'b0, "R1", "idle in reset",
              int'(cmd_valid_o), 0);
        check(page_size_o == '0 && page_count_o == '0 && !err_nodev_o && !err_unsup_o,
              "R1", "outputs zero in reset", int'(page_size_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(cmd_valid_o === 1'b1 && cmd_opcode_o == 8'h9F, "R1", "first request opcode",
              int'(cmd_opcode_o), 'h9F);
        wait_done("R1");
        check_result(VECS[0], 0);

        // vector table walk, each run launched by a start pulse
        for (int i = 0; i < NV; i++) begin
            cfg = VECS[i];
            restart();
            wait_done(tag_name(VECS[i].req));
            check_result(VECS[i], i);
        end

        // R11: start during an active read has no effect
        cfg = VECS[5];
        restart();
        while (!rx_valid_i) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done("R11");
        check(n_id == 1, "R11", "no extra identifier read", n_id, 1);
        check(page_size_o == 11'd1056, "R11", "result unchanged by busy start",
              int'(page_size_o), 1056);

        // R11: result held in done without a start
        repeat (10) @(negedge clk);
        check(done_o === 1'b1 && page_size_o == 11'd1056 && n_id == 1, "R11",
              "done state held", int'(page_size_o), 1056);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule